// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This block works out the next program counter for a 16-bit, word-addressed processor. Each cycle it takes the current PC, the four condition flags, the fetched instruction word and one register operand. From these it decides whether control transfers, and to where. It covers four kinds of instruction: conditional and unconditional relative jumps, jump-and-link, and jump through a register. It also forms the PC-relative address used by the address-of instruction and by PC-relative loads and stores.

A sequencer drives the inputs with `in_valid` and reads the results from the output side. By default the results are registered, so they appear one cycle after the inputs. Setting `REG_OUT=0` gives a purely combinational path instead. The flags register, the register file and the memory port stay outside the block. It returns a link value with a write strobe, a taken indication and an illegal-encoding indication.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid`, `taken`, `illegal` and `link_wr` are 0 and `next_pc` is 0.
- R2: A conditional jump is recognised by instruction bit 15 = 1. It carries a 3-bit condition code in bits 14..12, a polarity bit in bit 11 and a signed 11-bit offset in bits 10..0. When the selected condition equals the polarity bit, `taken`=1 and `next_pc` = PC+1+offset.
- R3: Any instruction that does not transfer control gives `taken`=0 and `next_pc` = PC+1.
- R4: The flags input is {Z,S,C,O}, with Z in bit 3 and O in bit 0. The condition codes select:
  - 1: Z
  - 2: S
  - 3: O
  - 4: C
  - 5: C|Z
  - 6: S^O
  - 7: (S^O)|Z
- R5: Condition code 0 with polarity 0 is taken whatever the flags are.
- R6: Condition code 0 with polarity 1 raises `illegal`, is not taken, and gives `next_pc` = PC+1.
- R7: Jump-and-link is a word with bits 15..14 = 01 and bits 13..11 = 110. It is taken to PC+1+imm, where imm is bits 7..0 sign-extended. It sets `link_wr`=1 with `link_val` = PC+1. No other instruction sets `link_wr`.
- R8: Jump-register is a word with bits 15..14 = 01 and bits 13..11 = 111. It is taken to `reg_val`+imm, with no +1.
- R9: `rel_addr` is PC+1+imm for address-of (bits 15..11 = 01001). It is PC+imm for PC-relative load (01100) and store (01101). It is 0 for every other word.
- R10: All PC and address arithmetic wraps modulo 2^16.
- R11: With registered outputs, `out_valid` and every result follow the inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an instruction this cycle |
| pc | input | 16 | Address of the current instruction |
| flags | input | 4 | {Z,S,C,O} condition flags |
| instr | input | 16 | Instruction word |
| reg_val | input | 16 | Source register value for jump-register |
| out_valid | output | 1 | Results are valid |
| next_pc | output | 16 | PC of the following instruction |
| taken | output | 1 | Control transfers away from PC+1 |
| illegal | output | 1 | Unassigned jump encoding seen |
| link_wr | output | 1 | Write `link_val` to the destination register |
| link_val | output | 16 | Return address, PC+1 |
| rel_addr | output | 16 | PC-relative address for address-of, load and store |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that no output is judged unless `out_valid` is high, so the results of idle cycles go unchecked. The stimulus keeps `in_valid` at 0 through reset. It mixes idle cycles with valid ones and drives every field with known values whenever `in_valid` is high. The condition table is swept across all codes, both polarities and all sixteen flag combinations. Wrap-around is exercised at both ends of the address space.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int INSN_W     = 16;
   localparam int COFF_W     = 11;
   localparam int IMM_W      = 8;
   localparam int CC_W       = 3;

   typedef struct packed {
      logic z;
      logic s;
      logic c;
      logic o;
   } flags_t;

   typedef enum logic [2:0] {
      K_SEQ   = 3'd0,
      K_COND  = 3'd1,
      K_JAL   = 3'd2,
      K_JR    = 3'd3,
      K_MOVA  = 3'd4,
      K_PCMEM = 3'd5
   } kind_e;

   function automatic kind_e classify(input logic [INSN_W-1:0] w);
      kind_e k;
      k = K_SEQ;
      if (w[15]) begin
         k = K_COND;
      end else if (w[15:14] == 2'b01) begin
         case (w[13:11])
            3'b001:         k = K_MOVA;
            3'b100, 3'b101: k = K_PCMEM;
            3'b110:         k = K_JAL;
            3'b111:         k = K_JR;
            default:        k = K_SEQ;
         endcase
      end
      return k;
   endfunction

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
   import npc_pkg::*;
(
   input  logic [CC_W-1:0] cc,
   input  logic            pol,
   input  flags_t          fl,
   output logic            take,
   output logic            bad
);

   logic sel;
   logic signed_lt;

   assign signed_lt = fl.s ^ fl.o;

   always_comb begin
      case (cc)
         3'd1:    sel = fl.z;
         3'd2:    sel = fl.s;
         3'd3:    sel = fl.o;
         3'd4:    sel = fl.c;
         3'd5:    sel = fl.c | fl.z;
         3'd6:    sel = signed_lt;
         3'd7:    sel = signed_lt | fl.z;
         default: sel = 1'b0;
      endcase
   end

   // code 0: polarity 0 means always, polarity 1 is unassigned
   assign bad  = (cc == '0) && pol;
   assign take = (cc == '0) ? ~pol : (sel == pol);

endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int PC_W = 16
) (
   input  kind_e             kind,
   input  logic              cond_take,
   input  logic [PC_W-1:0]   pc,
   input  logic [PC_W-1:0]   reg_val,
   input  logic [COFF_W-1:0] off_raw,
   output logic [PC_W-1:0]   nxt,
   output logic              tk,
   output logic              lw,
   output logic [PC_W-1:0]   lnk,
   output logic [PC_W-1:0]   rel
);

   logic [PC_W-1:0] pc_inc;
   logic [PC_W-1:0] off_c;
   logic [PC_W-1:0] off_i;

   assign pc_inc = pc + PC_W'(1);
   assign off_c  = {{(PC_W-COFF_W){off_raw[COFF_W-1]}}, off_raw};
   assign off_i  = {{(PC_W-IMM_W){off_raw[IMM_W-1]}}, off_raw[IMM_W-1:0]};
   assign lnk    = pc_inc;

   always_comb begin
      nxt = pc_inc;
      tk  = 1'b0;
      lw  = 1'b0;
      rel = '0;
      case (kind)
         K_COND: begin
            if (cond_take) begin
               nxt = pc_inc + off_c;
               tk  = 1'b1;
            end
         end
         K_JAL: begin
            nxt = pc_inc + off_i;
            tk  = 1'b1;
            lw  = 1'b1;
         end
         K_JR: begin
            nxt = reg_val + off_i;
            tk  = 1'b1;
         end
         K_MOVA:  rel = pc_inc + off_i;
         K_PCMEM: rel = pc + off_i;
         default: ;
      endcase
   end

endmodule

// File: rtl/npc_out_stage.sv
module npc_out_stage #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         v_in,
   input  logic [W-1:0] d_in,
   output logic         v_out,
   output logic [W-1:0] d_out
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_out <= 1'b0;
               d_out <= '0;
            end else begin
               v_out <= v_in;
               d_out <= d_in;
            end
         end
      end else begin : g_comb
         assign v_out = v_in;
         assign d_out = d_in;
      end
   endgenerate

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [PC_W-1:0]   pc,
   input  logic [3:0]        flags,
   input  logic [INSN_W-1:0] instr,
   input  logic [PC_W-1:0]   reg_val,
   output logic              out_valid,
   output logic [PC_W-1:0]   next_pc,
   output logic              taken,
   output logic              illegal,
   output logic              link_wr,
   output logic [PC_W-1:0]   link_val,
   output logic [PC_W-1:0]   rel_addr
);

   localparam int RES_W = 3 * PC_W + 3;

   generate
      if (PC_W < COFF_W + 1) begin : g_bad_width
         $error("npc_unit: PC_W must exceed the jump offset width");
      end
   endgenerate

   kind_e           kind;
   logic            c_take, c_bad;
   logic [PC_W-1:0] t_nxt, t_lnk, t_rel;
   logic            t_tk, t_lw;
   logic            ill_c;
   logic [RES_W-1:0] res_d, res_q;

   assign kind = classify(instr);

   npc_cond_eval u_cond (
      .cc   (instr[14:12]),
      .pol  (instr[11]),
      .fl   (flags_t'(flags)),
      .take (c_take),
      .bad  (c_bad)
   );

   npc_target #(.PC_W(PC_W)) u_tgt (
      .kind      (kind),
      .cond_take (c_take),
      .pc        (pc),
      .reg_val   (reg_val),
      .off_raw   (instr[COFF_W-1:0]),
      .nxt       (t_nxt),
      .tk        (t_tk),
      .lw        (t_lw),
      .lnk       (t_lnk),
      .rel       (t_rel)
   );

   assign ill_c = (kind == K_COND) && c_bad;
   assign res_d = {ill_c, t_tk, t_lw, t_nxt, t_lnk, t_rel};

   npc_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .v_in  (in_valid),
      .d_in  (res_d),
      .v_out (out_valid),
      .d_out (res_q)
   );

   assign {illegal, taken, link_wr, next_pc, link_val, rel_addr} = res_q;

   // an unassigned encoding never redirects fetch
   assert_illegal_falls_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && illegal |-> !taken && next_pc == link_val);

   // only a taken jump-and-link writes the link register
   assert_link_needs_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && link_wr |-> taken);

   // untaken flow continues at the return address PC+1
   assert_seq_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !taken |-> next_pc == link_val);

   // a write-back of link never coincides with a PC-relative address
   assert_link_rel_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && link_wr |-> rel_addr == '0);

   generate
      if (REG_OUT) begin : g_lat_chk
         assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> out_valid == $past(in_valid));
      end
   endgenerate

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] pc = '0;
   logic [3:0]  flags = '0;
   logic [15:0] instr = '0;
   logic [15:0] reg_val = '0;
   logic        out_valid, taken, illegal, link_wr;
   logic [15:0] next_pc, link_val, rel_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   npc_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc(pc), .flags(flags),
      .instr(instr), .reg_val(reg_val), .out_valid(out_valid), .next_pc(next_pc),
      .taken(taken), .illegal(illegal), .link_wr(link_wr), .link_val(link_val),
      .rel_addr(rel_addr)
   );

   typedef struct {
      bit          v;
      logic [15:0] npc;
      bit          tk;
      bit          il;
      bit          lw;
      logic [15:0] lnk;
      logic [15:0] rel;
      string       tag;
   } exp_t;

   exp_t sb[$];

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int sx(input int raw, input int bits);
      return (raw >= (1 << (bits - 1))) ? raw - (1 << bits) : raw;
   endfunction

   // reference built from the requirement text
   function automatic exp_t model(input logic [15:0] p, input logic [3:0] fl,
                                  input logic [15:0] w, input logic [15:0] r,
                                  input string tag);
      exp_t e;
      bit z, s, c, o, cv;
      int seq, imm, off;
      z = fl[3]; s = fl[2]; c = fl[1]; o = fl[0];
      seq = (int'(p) + 1) & 16'hFFFF;
      imm = sx(int'(w[7:0]), 8);
      off = sx(int'(w[10:0]), 11);
      e.v = 1'b1; e.tag = tag;
      e.npc = 16'(seq); e.tk = 0; e.il = 0; e.lw = 0;
      e.lnk = 16'(seq); e.rel = 16'h0;
      if (w[15] == 1'b1) begin
         case (w[14:12])
            3'd1: cv = z;
            3'd2: cv = s;
            3'd3: cv = o;
            3'd4: cv = c;
            3'd5: cv = c | z;
            3'd6: cv = s ^ o;
            3'd7: cv = (s ^ o) | z;
            default: cv = 0;
         endcase
         if (w[14:12] == 3'd0) begin
            if (w[11]) e.il = 1;
            else begin e.tk = 1; e.npc = 16'((seq + off) & 16'hFFFF); end
         end else if (cv == w[11]) begin
            e.tk = 1; e.npc = 16'((seq + off) & 16'hFFFF);
         end
      end else if (w[15:11] == 5'b01110) begin
         e.tk = 1; e.lw = 1; e.npc = 16'((seq + imm) & 16'hFFFF);
      end else if (w[15:11] == 5'b01111) begin
         e.tk = 1; e.npc = 16'((int'(r) + imm) & 16'hFFFF);
      end else if (w[15:11] == 5'b01001) begin
         e.rel = 16'((seq + imm) & 16'hFFFF);
      end else if (w[15:11] == 5'b01100 || w[15:11] == 5'b01101) begin
         e.rel = 16'((int'(p) + imm) & 16'hFFFF);
      end
      return e;
   endfunction

   function automatic logic [15:0] enc_c(input int cc, input int f, input int off);
      logic [10:0] o11;
      o11 = 11'(off);
      return {1'b1, 3'(cc), 1'(f), o11};
   endfunction

   function automatic logic [15:0] enc_i(input int op, input int imm);
      logic [7:0] i8;
      i8 = 8'(imm);
      return {2'b01, 3'(op), 3'd2, i8};
   endfunction

   task automatic send(input logic [15:0] p, input logic [3:0] fl, input logic [15:0] w,
                       input logic [15:0] r, input string tag);
      @(negedge clk);
      in_valid = 1'b1; pc = p; flags = fl; instr = w; reg_val = r;
      sb.push_back(model(p, fl, w, r, tag));
   endtask

   task automatic idle(input string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b0;
      e.v = 1'b0; e.tag = tag;
      e.npc = '0; e.tk = 0; e.il = 0; e.lw = 0; e.lnk = '0; e.rel = '0;
      sb.push_back(e);
   endtask

   // monitor: compares one queued item per cycle, away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "out_valid", int'(out_valid), int'(e.v));
            if (e.v) begin
               chk(e.tag, "next_pc", int'(next_pc), int'(e.npc));
               chk(e.tag, "taken", int'(taken), int'(e.tk));
               chk(e.tag, "illegal", int'(illegal), int'(e.il));
               chk(e.tag, "link_wr", int'(link_wr), int'(e.lw));
               chk(e.tag, "link_val", int'(link_val), int'(e.lnk));
               chk(e.tag, "rel_addr", int'(rel_addr), int'(e.rel));
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "out_valid", int'(out_valid), 0);
      chk("R1", "taken", int'(taken), 0);
      chk("R1", "illegal", int'(illegal), 0);
      chk("R1", "link_wr", int'(link_wr), 0);
      chk("R1", "next_pc", int'(next_pc), 0);
      rst_n = 1'b1;
      @(posedge clk); #2;
      chk("R1", "out_valid_after", int'(out_valid), 0);

      // R2: taken conditional, positive and negative offsets
      send(16'h0100, 4'b1000, enc_c(1, 1, 5), 16'h0, "R2");
      send(16'h0100, 4'b0000, enc_c(1, 0, -3), 16'h0, "R2");
      send(16'h2000, 4'b0010, enc_c(4, 1, 1023), 16'h0, "R2");
      // R3: untaken conditional and plain non-jump words
      send(16'h0100, 4'b0000, enc_c(1, 1, 5), 16'h0, "R3");
      send(16'h0042, 4'b1111, 16'h0123, 16'h0, "R3");
      send(16'h0042, 4'b1111, enc_i(2, 8'h55), 16'h0, "R3");
      // R11: bubble between valid items
      idle("R11");
      send(16'h0300, 4'b0000, enc_c(0, 0, 7), 16'h0, "R11");
      idle("R11");
      // R4: full condition sweep
      for (int cc = 1; cc < 8; cc++)
         for (int f = 0; f < 2; f++)
            for (int fl = 0; fl < 16; fl++)
               send(16'h1000, 4'(fl), enc_c(cc, f, -20), 16'h0, "R4");
      // R5: unconditional, any flags, extreme offset
      send(16'h4000, 4'b0000, enc_c(0, 0, -1024), 16'h0, "R5");
      send(16'h4000, 4'b1111, enc_c(0, 0, 12), 16'h0, "R5");
      // R6: unassigned encoding
      send(16'h4000, 4'b0000, enc_c(0, 1, 12), 16'h0, "R6");
      send(16'h4000, 4'b1111, enc_c(0, 1, -9), 16'h0, "R6");
      // R7: jump-and-link
      send(16'h0500, 4'b0000, enc_i(6, -128), 16'h0, "R7");
      send(16'h0500, 4'b0101, enc_i(6, 127), 16'h0, "R7");
      // R8: jump-register, no +1
      send(16'h0500, 4'b0000, enc_i(7, -4), 16'h1234, "R8");
      send(16'h0500, 4'b0000, enc_i(7, 0), 16'hBEEF, "R8");
      // R9: PC-relative addresses
      send(16'h0800, 4'b0000, enc_i(1, 16), 16'h0, "R9");
      send(16'h0800, 4'b0000, enc_i(4, -16), 16'h0, "R9");
      send(16'h0800, 4'b0000, enc_i(5, 3), 16'h0, "R9");
      send(16'h0800, 4'b0000, 16'h2345, 16'h0, "R9");
      // R10: wrap-around both ways
      send(16'hFFFF, 4'b0000, enc_c(0, 0, 1), 16'h0, "R10");
      send(16'h0000, 4'b0000, enc_i(4, -1), 16'h0, "R10");
      send(16'h0000, 4'b0000, enc_i(6, -2), 16'h0, "R10");
      send(16'h0000, 4'b0000, enc_i(7, 32), 16'hFFF0, "R10");
      send(16'hFFFF, 4'b0000, enc_i(1, 0), 16'h0, "R10");
      @(negedge clk);
      in_valid = 1'b0;
      wait (sb.size() == 0);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule